// File: doc/BRIEF.md
# Sequential Page Program Guard

This block sits in front of the command sequencer of a NAND flash controller and vets each page program request before any bus cycle is issued. The flash requires that pages inside an erase block are written in rising page order, and that each page takes at most one program per 512-byte segment, split into up to four partial writes. The guard keeps a small table of recently opened blocks. For each of them it records the last page programmed and which segments of that page are already written. It answers each request with a two-bit verdict. For a granted partial write it also returns a fill mask that names the segments the sequencer must send as all-ones bytes.

Erase requests pass through the same channel. They are always granted, and they return the tracked block to a fresh state. The table holds a parameterised number of entries. When a new block must be tracked and the table is full, the entry allocated earliest is replaced. A program request for an untracked block is only accepted at page 0, which opens a new entry. Any other page on an untracked block is reported as a table miss.

Top module: `pgguard_top`

## Requirements
- R1: Every request accepted while `reqValid` is high gets exactly one response, with `rspValid` high, on the clock edge that follows. `rspValid` is low in every cycle that does not follow a request.
- R2: After reset the table is empty, and `rspValid`, `rspCode` and `rspFill` are all zero.
- R3: A program request to a tracked block whose page is lower than that block's last programmed page is rejected with code 01 (out of order).
- R4: A program request to the same page as the last programmed one is granted if its segments are disjoint from the segments already written on that page, and is rejected with code 10 (segment used) if any segment overlaps. Segment mask bit i stands for bytes 512*i to 512*i+511 of the page.
- R5: A program request to a tracked block for a page above the last programmed page is granted. It starts a new page whose written segments are exactly the requested ones.
- R6: A segment mask of 0000 means the whole page, that is all four segments.
- R7: A program request to an untracked block is rejected with code 11 (table miss) unless its page is 0. A page 0 request opens an entry and is granted.
- R8: An erase request is always granted with fill 0000. Afterwards the block is tracked with no page programmed and no segment written, so its next program request is granted at any page.
- R9: A granted program returns in `rspFill` the complement of the effective segment mask, naming the segments to be sent as all-ones bytes. A reject or an erase returns 0000.
- R10: When a new entry is needed and all entries are in use, the entry allocated earliest is replaced. After that, the evicted block is untracked.
- R11: A rejected request leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqErase | input | 1 | 1: erase request, 0: program request |
| reqBlock | input | 11 | Target block number |
| reqPage | input | 6 | Page within the block (ignored for erase) |
| reqSegMask | input | 4 | Segments to program, bit i is segment i, 0000 means the whole page |
| rspValid | output | 1 | Verdict present this cycle |
| rspCode | output | 2 | 00 granted, 01 out of order, 10 segment used, 11 table miss |
| rspFill | output | 4 | Segments to be padded with all-ones bytes |

## Verification
The verdict and the fill mask pass through a single register. Both are therefore due on the first rising edge after the request is presented, and the table update takes effect at that same edge. The bench drives each request on a falling edge, samples the response one time unit after the next rising edge, and then compares it with a bench model that it updates at that moment. The next request therefore already sees the updated table, which is what back-to-back requests see in the design. Idle cycles are sampled the same way, to confirm that no verdict appears without a request.

// File: rtl/pgguard_pkg.sv
package pgguard_pkg;

  typedef enum logic [1:0] {
    RSP_GRANT   = 2'b00,
    RSP_ORDER   = 2'b01,
    RSP_SEGUSED = 2'b10,
    RSP_MISS    = 2'b11
  } rsp_code_e;

  // strobes from the decision logic to the tracking table
  typedef struct packed {
    logic allocEntry;  // claim the victim slot for the request block
    logic clearEntry;  // forget page progress of the target slot
    logic recordProg;  // store page and segment marks in the target slot
    logic mergeMarks;  // OR new segments into existing marks (same page)
  } tbl_strobe_t;

endpackage

// File: rtl/pgguard_table.sv
module pgguard_table
  import pgguard_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int BLOCK_W     = 11,
  parameter int PAGE_W      = 6,
  parameter int SEG_N       = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  tbl_strobe_t        strobe,
  input  logic [BLOCK_W-1:0] reqBlock,
  input  logic [PAGE_W-1:0]  reqPage,
  input  logic [SEG_N-1:0]   effMask,
  output logic               hit,
  output logic               entStarted,
  output logic [PAGE_W-1:0]  entLast,
  output logic [SEG_N-1:0]   entMarks
);

  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  logic [NUM_ENTRIES-1:0] entValid;
  logic [BLOCK_W-1:0]     entBlock   [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] entStart;
  logic [PAGE_W-1:0]      entPage    [NUM_ENTRIES];
  logic [SEG_N-1:0]       entSeg     [NUM_ENTRIES];
  logic [IDX_W-1:0]       victimIdx;
  logic [NUM_ENTRIES-1:0] hitVec;
  logic [IDX_W-1:0]       hitIdx;
  logic [IDX_W-1:0]       tgtIdx;

  genvar g;
  generate
    for (g = 0; g < NUM_ENTRIES; g++) begin : gen_match
      assign hitVec[g] = entValid[g] && (entBlock[g] == reqBlock);
    end
  endgenerate

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (hitVec[i]) hitIdx = IDX_W'(i);
    end
  end

  assign hit        = |hitVec;
  assign tgtIdx     = hit ? hitIdx : victimIdx;
  assign entStarted = hit && entStart[hitIdx];
  assign entLast    = entPage[hitIdx];
  assign entMarks   = entSeg[hitIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid  <= '0;
      entStart  <= '0;
      victimIdx <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        entBlock[i] <= '0;
        entPage[i]  <= '0;
        entSeg[i]   <= '0;
      end
    end else begin
      if (strobe.allocEntry) begin
        entValid[tgtIdx] <= 1'b1;
        entBlock[tgtIdx] <= reqBlock;
        victimIdx        <= (victimIdx == LAST_IDX) ? '0 : victimIdx + 1'b1;
      end
      if (strobe.clearEntry) begin
        entStart[tgtIdx] <= 1'b0;
        entPage[tgtIdx]  <= '0;
        entSeg[tgtIdx]   <= '0;
      end
      if (strobe.recordProg) begin
        entStart[tgtIdx] <= 1'b1;
        entPage[tgtIdx]  <= reqPage;
        entSeg[tgtIdx]   <= strobe.mergeMarks ? (entSeg[tgtIdx] | effMask) : effMask;
      end
    end
  end

  // R10: a block never occupies two slots
  a_r10_single_slot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R10: a new slot is only claimed for an untracked block
  a_r10_alloc_on_miss: assert property (@(posedge clk) disable iff (!rstN)
    strobe.allocEntry |-> !hit);

  // R4: merging never rewrites a segment already marked
  a_r4_no_rewrite: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.recordProg && strobe.mergeMarks) |-> ((effMask & entSeg[tgtIdx]) == '0));

  // R3: a recorded page never goes below the stored one
  a_r3_ascending: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.recordProg && hit && entStart[tgtIdx]) |-> (reqPage >= entPage[tgtIdx]));

  // R8: the entry count only grows
  a_r8_valid_grows: assert property (@(posedge clk) disable iff (!rstN)
    $countones(entValid) >= $countones($past(entValid)));

endmodule

// File: rtl/pgguard_ctrl.sv
module pgguard_ctrl
  import pgguard_pkg::*;
#(
  parameter int PAGE_W = 6,
  parameter int SEG_N  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqErase,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic [SEG_N-1:0]  reqSegMask,
  input  logic              hit,
  input  logic              entStarted,
  input  logic [PAGE_W-1:0] entLast,
  input  logic [SEG_N-1:0]  entMarks,
  output tbl_strobe_t       strobe,
  output logic [SEG_N-1:0]  effMask,
  output logic              rspValid,
  output rsp_code_e         rspCode,
  output logic [SEG_N-1:0]  rspFill
);

  rsp_code_e        nextCode;
  logic [SEG_N-1:0] nextFill;

  assign effMask = (reqSegMask == '0) ? '1 : reqSegMask;

  always_comb begin
    strobe   = '0;
    nextCode = RSP_GRANT;
    nextFill = '0;
    if (reqValid) begin
      if (reqErase) begin
        strobe.clearEntry = 1'b1;
        strobe.allocEntry = !hit;
      end else if (!hit) begin
        if (reqPage == '0) begin
          strobe.allocEntry = 1'b1;
          strobe.recordProg = 1'b1;
          nextFill          = ~effMask;
        end else begin
          nextCode = RSP_MISS;
        end
      end else if (!entStarted || reqPage > entLast) begin
        strobe.recordProg = 1'b1;
        nextFill          = ~effMask;
      end else if (reqPage < entLast) begin
        nextCode = RSP_ORDER;
      end else if ((effMask & entMarks) != '0) begin
        nextCode = RSP_SEGUSED;
      end else begin
        strobe.recordProg = 1'b1;
        strobe.mergeMarks = 1'b1;
        nextFill          = ~effMask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspCode  <= RSP_GRANT;
      rspFill  <= '0;
    end else begin
      rspValid <= reqValid;
      rspCode  <= nextCode;
      rspFill  <= nextFill;
    end
  end

  // R9: rejects carry no padding
  a_r9_fill_on_grant: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCode != RSP_GRANT) |-> (rspFill == '0));

  // R11: a rejected request produces no table strobe
  a_r11_reject_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && nextCode != RSP_GRANT) |-> (strobe == '0));

endmodule

// File: rtl/pgguard_top.sv
module pgguard_top
  import pgguard_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int BLOCK_W     = 11,
  parameter int PAGE_W      = 6,
  parameter int SEG_N       = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqErase,
  input  logic [BLOCK_W-1:0] reqBlock,
  input  logic [PAGE_W-1:0]  reqPage,
  input  logic [SEG_N-1:0]   reqSegMask,
  output logic               rspValid,
  output logic [1:0]         rspCode,
  output logic [SEG_N-1:0]   rspFill
);

  tbl_strobe_t       strobe;
  logic [SEG_N-1:0]  effMask;
  logic              hit;
  logic              entStarted;
  logic [PAGE_W-1:0] entLast;
  logic [SEG_N-1:0]  entMarks;
  rsp_code_e         codeQ;

  pgguard_ctrl #(.PAGE_W(PAGE_W), .SEG_N(SEG_N)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqErase(reqErase), .reqPage(reqPage), .reqSegMask(reqSegMask),
    .hit(hit), .entStarted(entStarted), .entLast(entLast), .entMarks(entMarks),
    .strobe(strobe), .effMask(effMask),
    .rspValid(rspValid), .rspCode(codeQ), .rspFill(rspFill)
  );

  pgguard_table #(.NUM_ENTRIES(NUM_ENTRIES), .BLOCK_W(BLOCK_W), .PAGE_W(PAGE_W), .SEG_N(SEG_N)) u_table (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqBlock(reqBlock), .reqPage(reqPage), .effMask(effMask),
    .hit(hit), .entStarted(entStarted), .entLast(entLast), .entMarks(entMarks)
  );

  assign rspCode = codeQ;

  // R1: one verdict per request, on the next edge
  a_r1_resp_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

endmodule

// File: tb/pgguard_top_bench.sv
module pgguard_top_bench;

  localparam int NE = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqErase = 1'b0;
  logic [10:0] reqBlock = '0;
  logic [5:0]  reqPage = '0;
  logic [3:0]  reqSegMask = '0;
  logic        rspValid;
  logic [1:0]  rspCode;
  logic [3:0]  rspFill;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  // bench model of the tracking table
  bit       mVld [NE];
  int       mBlk [NE];
  bit       mStart [NE];
  int       mLast [NE];
  bit [3:0] mSeg [NE];
  int       mPtr = 0;

  always #2 clk = ~clk;

  pgguard_top u_pgguard_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqErase(reqErase),
    .reqBlock(reqBlock), .reqPage(reqPage), .reqSegMask(reqSegMask),
    .rspValid(rspValid), .rspCode(rspCode), .rspFill(rspFill)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected < 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  function automatic int findIdx(int blk);
    int r = -1;
    for (int i = 0; i < NE; i++) if (mVld[i] && mBlk[i] == blk) r = i;
    return r;
  endfunction

  task automatic applyReq(bit er, int blk, int pg, bit [3:0] msk, string tag);
    bit [1:0] expCode;
    bit [3:0] expFill;
    bit [3:0] eff;
    int idx;
    eff = (msk == 4'b0) ? 4'hF : msk;
    idx = findIdx(blk);
    expCode = 2'b00;
    expFill = 4'b0;
    if (er) begin
      if (idx < 0) begin
        idx = mPtr; mPtr = (mPtr + 1) % NE;
        mVld[idx] = 1; mBlk[idx] = blk;
      end
      mStart[idx] = 0; mLast[idx] = 0; mSeg[idx] = 0;
    end else if (idx < 0) begin
      if (pg == 0) begin
        idx = mPtr; mPtr = (mPtr + 1) % NE;
        mVld[idx] = 1; mBlk[idx] = blk;
        mStart[idx] = 1; mLast[idx] = 0; mSeg[idx] = eff;
        expFill = ~eff;
      end else expCode = 2'b11;
    end else if (!mStart[idx] || pg > mLast[idx]) begin
      mStart[idx] = 1; mLast[idx] = pg; mSeg[idx] = eff;
      expFill = ~eff;
    end else if (pg < mLast[idx]) begin
      expCode = 2'b01;
    end else if ((eff & mSeg[idx]) != 0) begin
      expCode = 2'b10;
    end else begin
      mSeg[idx] |= eff;
      expFill = ~eff;
    end
    @(negedge clk);
    reqValid = 1; reqErase = er; reqBlock = 11'(blk); reqPage = 6'(pg); reqSegMask = msk;
    @(posedge clk);
    #1;
    reqValid = 0;
    vectors++;
    if (rspValid !== 1'b1 || rspCode !== expCode || rspFill !== expFill) begin
      fails++;
      $display("FAIL %s: actual valid=%b code=%b fill=%b expected valid=1 code=%b fill=%b",
               tag, rspValid, rspCode, rspFill, expCode, expFill);
    end
  endtask

  task automatic checkIdle(string tag);
    @(negedge clk);
    @(posedge clk);
    #1;
    vectors++;
    if (rspValid !== 1'b0) begin
      fails++;
      $display("FAIL %s: actual valid=%b expected valid=0", tag, rspValid);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < NE; i++) begin
      mVld[i] = 0; mBlk[i] = 0; mStart[i] = 0; mLast[i] = 0; mSeg[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    vectors++;
    if (rspValid !== 1'b0 || rspCode !== 2'b00 || rspFill !== 4'b0) begin
      fails++;
      $display("FAIL R2 reset: actual valid=%b code=%b fill=%b expected 0 00 0000",
               rspValid, rspCode, rspFill);
    end
    @(negedge clk);
    rstN = 1;

    applyReq(0, 7, 3, 4'b0001, "R2 empty table miss");
    applyReq(0, 5, 0, 4'b0001, "R7 open at page 0 R9 fill");
    applyReq(0, 5, 0, 4'b0010, "R4 disjoint segment");
    applyReq(0, 5, 0, 4'b0011, "R4 overlapping segment");
    applyReq(0, 5, 0, 4'b0100, "R11 state kept after reject");
    applyReq(0, 5, 0, 4'b1000, "R4 fourth segment");
    applyReq(0, 5, 2, 4'b0000, "R6 zero mask whole page R5");
    applyReq(0, 5, 1, 4'b0001, "R3 lower page");
    applyReq(0, 5, 2, 4'b1000, "R6 whole page marked");
    applyReq(0, 5, 63, 4'b1000, "R5 higher page");
    applyReq(1, 5, 0, 4'b0000, "R8 erase granted");
    applyReq(0, 5, 10, 4'b0001, "R8 fresh after erase");
    checkIdle("R1 idle no response");
    applyReq(0, 1, 0, 4'b1111, "R7 open block 1");
    applyReq(0, 2, 0, 4'b0101, "R7 open block 2");
    applyReq(0, 3, 0, 4'b1010, "R7 open block 3");
    applyReq(0, 4, 0, 4'b0001, "R10 evict oldest");
    applyReq(0, 5, 11, 4'b0001, "R10 evicted block misses");
    applyReq(0, 1, 1, 4'b0001, "R10 survivor still tracked");
    applyReq(1, 9, 0, 4'b0000, "R8 erase untracked block");
    applyReq(0, 9, 40, 4'b0110, "R8 any page after erase");
    applyReq(0, 2, 0, 4'b0100, "R4 overlap on tracked");

    for (int n = 0; n < 4000; n++) begin
      bit er;
      int blk, pg;
      bit [3:0] msk;
      er  = ($urandom_range(0, 9) == 0);
      blk = $urandom_range(0, 5);
      pg  = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(0, 7);
      msk = 4'($urandom_range(0, 15));
      applyReq(er, blk, pg, msk, "R3 R4 R5 R7 R10 random");
      if ($urandom_range(0, 15) == 0) checkIdle("R1 random idle");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule